// File: doc/BRIEF.md
# Threshold-Triggered Peak Event Recorder

This block is the per-channel front end of an event-driven readout. It watches a stream of 12-bit ADC samples and compares each valid sample with a programmable threshold. When a sample rises above the threshold, the block opens an event and latches the value of a free-running 48-bit time counter. While the event stays open, it keeps the largest sample seen.

The first sample at or below the threshold closes the event. The block then turns the channel number, the crossing time and the peak into a packet and queues it in a small local FIFO. Packets leave as 16-bit beats over a ready/valid handshake. The downstream shared FIFO takes a beat only while it asserts ready.

If the local FIFO is full when an event closes, the event is lost. A saturating counter records each lost event. A configuration enable bit silences the channel completely.

Top module: `peak_event_recorder`

## Requirements
- R1: A valid sample strictly greater than the threshold, seen while the channel is armed and enabled, opens an event and captures the value of `time_i` in that same cycle as the event time.
- R2: The packet's peak field is the maximum of all samples strictly above the threshold within the event, the opening sample included.
- R3: The first valid sample less than or equal to the threshold closes the event, and exactly one packet is queued for it.
- R4: A sample exactly equal to the threshold never opens an event. If an event is closed by a sample equal to the threshold, no new event opens until a sample strictly below the threshold has been seen. A closing sample strictly below the threshold re-arms the channel at once.
- R5: A packet is 5 beats of 16 bits, in this order: beat 0 = channel ID zero-extended; beats 1, 2, 3 = event time bits [47:32], [31:16], [15:0]; beat 4 = peak zero-extended.
- R6: The local FIFO holds FIFO_DEPTH packets (default 4). An event that closes while the FIFO is full is discarded, and `drop_count_o` increments. The counter saturates at 2^DROP_W-1 (255 by default) and never decreases.
- R7: A beat advances only on a cycle where `pkt_valid_o` and `pkt_ready_i` are both high. While stalled, the data stays stable. `pkt_last_o` is high on beat 4 only.
- R8: While `cfg_enable_i` is low, no event opens. An open event is discarded without a packet, and the channel is armed again when the enable returns.
- R9: After reset, `pkt_valid_o` is low and `drop_count_o` is 0.
- R10: Samples with `sample_valid_i` low are ignored: they neither open, extend nor close an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable_i | input | 1 | Channel enable |
| threshold_i | input | 12 | Trigger threshold |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 12 | ADC sample |
| time_i | input | 48 | Free-running time counter |
| pkt_data_o | output | 16 | Packet beat |
| pkt_valid_o | output | 1 | Beat valid |
| pkt_last_o | output | 1 | Final beat of a packet |
| pkt_ready_i | input | 1 | Downstream ready |
| drop_count_o | output | 8 | Saturating lost-event count |

## Verification
A wrong detector state shows up as a missing packet or an extra packet. The scoreboard catches it once the next expected packet is due to leave the FIFO, which is within a few cycles when ready is high. A peak or time-stamp register that updates on the wrong sample corrupts a single beat of the next packet. A FIFO that miscounts its occupancy either drops events early or replays stale entries: the drop count gives this away right after an overflow burst, and a duplicated packet gives it away at drain. A beat index that slips shows as `pkt_last_o` on the wrong beat, or as data that changes while the output is stalled.

// File: rtl/evr_pkg.sv
package evr_pkg;
   typedef enum logic [1:0] {
      DET_ARMED  = 2'd0,
      DET_ACTIVE = 2'd1,
      DET_HOLD   = 2'd2
   } det_state_e;
endpackage

// File: rtl/evr_detector.sv
module evr_detector
   import evr_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int TS_W     = 48
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable_i,
   input  logic [SAMPLE_W-1:0] thr_i,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic [TS_W-1:0]     time_i,
   output logic                done_o,
   output logic [TS_W-1:0]     ts_o,
   output logic [SAMPLE_W-1:0] peak_o
);
   det_state_e          state_q;
   logic [TS_W-1:0]     ts_q;
   logic [SAMPLE_W-1:0] peak_q;
   logic                above, below;

   assign above = smp_i > thr_i;
   assign below = smp_i < thr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DET_ARMED;
         ts_q    <= '0;
         peak_q  <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!enable_i) begin
            state_q <= DET_ARMED;
         end else if (smp_valid_i) begin
            unique case (state_q)
               DET_ARMED: if (above) begin
                  state_q <= DET_ACTIVE;
                  ts_q    <= time_i;
                  peak_q  <= smp_i;
               end
               DET_ACTIVE: if (above) begin
                  if (smp_i > peak_q) peak_q <= smp_i;
               end else begin
                  done_o  <= 1'b1;
                  state_q <= below ? DET_ARMED : DET_HOLD;
               end
               DET_HOLD: if (below) state_q <= DET_ARMED;
               default: state_q <= DET_ARMED;
            endcase
         end
      end
   end

   assign ts_o   = ts_q;
   assign peak_o = peak_q;

   // R3: a completed event is always caused by an enabled, valid sample at or below threshold
   p_end_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(enable_i && smp_valid_i && (smp_i <= thr_i)));

   // R8: a disabled channel never reports an event on the next cycle
   p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> !done_o);

   // R10: without a sample strobe nothing completes
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid_i |=> !done_o);
endmodule

// File: rtl/evr_fifo.sv
module evr_fifo #(
   parameter int W     = 60,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic [W-1:0] data_o,
   output logic         full_o,
   output logic         empty_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("evr_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign full_o  = count == CNT_W'(DEPTH);
   assign empty_o = count == '0;
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign data_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   // R6: occupancy never exceeds the configured depth
   p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
endmodule

// File: rtl/evr_packer.sv
module evr_packer #(
   parameter int               ID_W       = 5,
   parameter logic [ID_W-1:0]  CHANNEL_ID = '0,
   parameter int               TS_W       = 48,
   parameter int               SAMPLE_W   = 12,
   parameter int               BEAT_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                entry_valid_i,
   input  logic [TS_W-1:0]     ts_i,
   input  logic [SAMPLE_W-1:0] peak_i,
   input  logic                ready_i,
   output logic [BEAT_W-1:0]   data_o,
   output logic                valid_o,
   output logic                last_o,
   output logic                pop_o
);
   localparam int TS_BEATS = (TS_W + BEAT_W - 1) / BEAT_W;
   localparam int NBEATS   = TS_BEATS + 2;
   localparam int IDX_W    = $clog2(NBEATS);
   localparam int PAD_W    = TS_BEATS * BEAT_W;

   if (SAMPLE_W > BEAT_W || ID_W > BEAT_W) begin : g_bad_beat
      $error("evr_packer: BEAT_W too narrow for ID or sample");
   end

   logic [BEAT_W-1:0] beat_w [NBEATS];
   logic [PAD_W-1:0]  ts_pad;
   logic [IDX_W-1:0]  beat_q;
   logic              fire;

   assign ts_pad             = PAD_W'(ts_i);
   assign beat_w[0]          = BEAT_W'(CHANNEL_ID);
   assign beat_w[NBEATS-1]   = BEAT_W'(peak_i);

   for (genvar i = 0; i < TS_BEATS; i++) begin : g_ts_beat
      assign beat_w[1+i] = ts_pad[(TS_BEATS-1-i)*BEAT_W +: BEAT_W];
   end

   assign valid_o = entry_valid_i;
   assign data_o  = beat_w[beat_q];
   assign last_o  = beat_q == IDX_W'(NBEATS - 1);
   assign fire    = valid_o && ready_i;
   assign pop_o   = fire && last_o;

   always_ff @(posedge clk) begin
      if (!rst_n)     beat_q <= '0;
      else if (fire)  beat_q <= last_o ? '0 : beat_q + 1'b1;
   end

   // R7: a stalled beat holds its value and stays valid
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));
endmodule

// File: rtl/peak_event_recorder.sv
module peak_event_recorder #(
   parameter int              SAMPLE_W   = 12,
   parameter int              TS_W       = 48,
   parameter int              BEAT_W     = 16,
   parameter int              ID_W       = 5,
   parameter logic [ID_W-1:0] CHANNEL_ID = '0,
   parameter int              FIFO_DEPTH = 4,
   parameter int              DROP_W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_enable_i,
   input  logic [SAMPLE_W-1:0] threshold_i,
   input  logic                sample_valid_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic [TS_W-1:0]     time_i,
   output logic [BEAT_W-1:0]   pkt_data_o,
   output logic                pkt_valid_o,
   output logic                pkt_last_o,
   input  logic                pkt_ready_i,
   output logic [DROP_W-1:0]   drop_count_o
);
   localparam int ENTRY_W = TS_W + SAMPLE_W;

   if (DROP_W < 1) begin : g_bad_drop
      $error("peak_event_recorder: DROP_W must be at least 1");
   end

   logic                done, fifo_full, fifo_empty, pop;
   logic [TS_W-1:0]     ev_ts, head_ts;
   logic [SAMPLE_W-1:0] ev_peak, head_peak;
   logic [ENTRY_W-1:0]  head;
   logic [DROP_W-1:0]   drop_q;

   evr_detector #(.SAMPLE_W(SAMPLE_W), .TS_W(TS_W)) u_det (
      .clk(clk), .rst_n(rst_n), .enable_i(cfg_enable_i), .thr_i(threshold_i),
      .smp_valid_i(sample_valid_i), .smp_i(sample_i), .time_i(time_i),
      .done_o(done), .ts_o(ev_ts), .peak_o(ev_peak));

   evr_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(done), .data_i({ev_ts, ev_peak}),
      .pop_i(pop), .data_o(head), .full_o(fifo_full), .empty_o(fifo_empty));

   assign {head_ts, head_peak} = head;

   evr_packer #(.ID_W(ID_W), .CHANNEL_ID(CHANNEL_ID), .TS_W(TS_W),
                .SAMPLE_W(SAMPLE_W), .BEAT_W(BEAT_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .entry_valid_i(!fifo_empty), .ts_i(head_ts),
      .peak_i(head_peak), .ready_i(pkt_ready_i), .data_o(pkt_data_o),
      .valid_o(pkt_valid_o), .last_o(pkt_last_o), .pop_o(pop));

   always_ff @(posedge clk) begin
      if (!rst_n)
         drop_q <= '0;
      else if (done && fifo_full && drop_q != {DROP_W{1'b1}})
         drop_q <= drop_q + 1'b1;
   end

   assign drop_count_o = drop_q;

   // R6: the lost-event count never goes down
   p_drop_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (drop_count_o >= $past(drop_count_o)));

   // R6: the count only moves when an event meets a full queue
   p_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(done && fifo_full)) |=> $stable(drop_count_o));

   // R9: no valid output straight out of reset
   p_reset_idle_r9: assert property (@(posedge clk)
      !rst_n |=> !pkt_valid_o);
endmodule

// File: tb/test_peak_event_recorder.sv
module test_peak_event_recorder;
   localparam logic [4:0]  CID = 5'd19;
   localparam logic [47:0] T0  = 48'hA5C3_1234_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable_i = 1'b1;
   logic [11:0] threshold_i = 12'd1000;
   logic        sample_valid_i = 1'b0;
   logic [11:0] sample_i = '0;
   logic [47:0] time_i = '0;
   logic [15:0] pkt_data_o;
   logic        pkt_valid_o, pkt_last_o;
   logic        pkt_ready_i = 1'b0;
   logic [7:0]  drop_count_o;

   always #5 clk = ~clk;

   peak_event_recorder #(.CHANNEL_ID(CID)) i_peak_event_recorder (
      .clk(clk), .rst_n(rst_n), .cfg_enable_i(cfg_enable_i), .threshold_i(threshold_i),
      .sample_valid_i(sample_valid_i), .sample_i(sample_i), .time_i(time_i),
      .pkt_data_o(pkt_data_o), .pkt_valid_o(pkt_valid_o), .pkt_last_o(pkt_last_o),
      .pkt_ready_i(pkt_ready_i), .drop_count_o(drop_count_o));

   int vectors = 0;
   int fails   = 0;
   logic [64:0] expq [$];   // {id, ts, peak}

   // bench model of the detector
   int          m_state = 0; // 0 armed, 1 active, 2 hold
   logic [47:0] m_ts;
   int          m_peak;
   int          tick = 0;
   int          budget = 1_000_000;
   int          m_drops = 0;
   logic        en_v = 1'b1;
   int          ready_mode = 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input bit v, input int s);
      int thr;
      @(negedge clk);
      thr = int'(threshold_i);
      cfg_enable_i   = en_v;
      sample_valid_i = v;
      sample_i       = 12'(s);
      time_i         = T0 + 48'(tick);
      if (!en_v) m_state = 0;
      else if (v) begin
         case (m_state)
            0: if (s > thr) begin m_state = 1; m_ts = time_i; m_peak = s; end
            1: if (s > thr) begin if (s > m_peak) m_peak = s; end
               else begin
                  if (budget > 0) begin expq.push_back({CID, m_ts, 12'(m_peak)}); budget--; end
                  else m_drops++;
                  m_state = (s < thr) ? 0 : 2;
               end
            default: if (s < thr) m_state = 0;
         endcase
      end
      tick++;
   endtask

   // monitor / scoreboard
   logic [15:0] beats [5];
   int          bidx = 0;
   logic        prev_stall = 1'b0;
   logic [15:0] prev_data;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(pkt_valid_o && pkt_data_o == prev_data, "R7 stall hold", pkt_data_o, prev_data);
         prev_stall = pkt_valid_o && !pkt_ready_i;
         prev_data  = pkt_data_o;
         if (pkt_valid_o && pkt_ready_i) begin
            if (pkt_last_o != (bidx == 4))
               check(0, "R7 last flag", pkt_last_o, bidx == 4);
            beats[bidx] = pkt_data_o;
            bidx++;
            if (bidx == 5) begin
               bidx = 0;
               if (expq.size() == 0) check(0, "R3 unexpected packet", beats[3], 0);
               else begin
                  logic [64:0] e;
                  logic [79:0] got, want;
                  e = expq.pop_front();
                  got  = {beats[0], beats[1], beats[2], beats[3], beats[4]};
                  want = {11'd0, e[64:60], e[59:44], e[43:28], e[27:12], 4'd0, e[11:0]};
                  check(got == want, "R1 R2 R5 packet", got[63:0], want[63:0]);
               end
            end
         end
      end
   end

   // downstream ready driver
   initial forever begin
      @(posedge clk); #2;
      pkt_ready_i = (ready_mode == 1) ? 1'b1 :
                    (ready_mode == 2) ? (($urandom % 3) != 0) : 1'b0;
   end

   task automatic drain();
      ready_mode = 1;
      while (expq.size() != 0 || bidx != 0) @(posedge clk);
      repeat (4) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(!pkt_valid_o, "R9 valid after reset", pkt_valid_o, 0);
      check(drop_count_o == 0, "R9 drop count after reset", drop_count_o, 0);
      rst_n = 1'b1;

      // R1 R2 R3 basic event
      put(1, 500); put(1, 1200); put(1, 1800); put(1, 1500); put(1, 900);
      // R4 threshold equality
      put(1, 1000); put(1, 1001); put(1, 1000); put(1, 2000); put(1, 1000);
      put(1, 999);  put(1, 3000); put(1, 100);
      // R10 gaps with junk while strobe low
      put(1, 2200); put(0, 4095); put(1, 2100); put(0, 0); put(1, 2300); put(0, 10); put(1, 50);
      drain();
      check(expq.size() == 0, "R3 R4 R10 all packets seen", expq.size(), 0);

      // R8 disable
      en_v = 0; put(1, 3000); put(1, 100); put(1, 3500); put(1, 100);
      en_v = 1; put(1, 2500); put(1, 2600); en_v = 0; put(1, 2700);
      en_v = 1; put(1, 100); put(1, 2800); put(1, 200);
      drain();
      check(expq.size() == 0, "R8 disable", expq.size(), 0);

      // R7 random stalls with random events
      ready_mode = 2;
      for (int k = 0; k < 25; k++) begin
         put(1, 1001 + int'($urandom % 3000));
         put(1, 1001 + int'($urandom % 3000));
         put(1, int'($urandom % 1000));
         for (int g = 0; g < 12; g++) put(0, 0);
      end
      drain();
      check(expq.size() == 0, "R7 stalled traffic", expq.size(), 0);

      // R6 overflow
      ready_mode = 0; repeat (3) @(posedge clk);
      budget = 4; m_drops = 0;
      for (int k = 0; k < 6; k++) begin put(1, 1100 + k); put(1, 10); end
      repeat (4) @(posedge clk); @(negedge clk);
      check(drop_count_o == 8'd2, "R6 drop count", drop_count_o, 2);
      check(pkt_valid_o, "R6 queue holds packets", pkt_valid_o, 1);
      for (int k = 0; k < 300; k++) begin put(1, 1500); put(1, 10); end
      repeat (4) @(posedge clk); @(negedge clk);
      check(drop_count_o == 8'd255, "R6 drop saturation", drop_count_o, 255);
      budget = 1_000_000;
      drain();
      check(expq.size() == 0, "R6 kept packets drained", expq.size(), 0);
      put(1, 3333); put(1, 1);
      drain();
      check(drop_count_o == 8'd255, "R6 count held", drop_count_o, 255);
      check(!pkt_valid_o, "R3 idle after drain", pkt_valid_o, 0);
      finish_run();
   end
endmodule